// File: doc/BRIEF.md
# Light-Load Burst Gating and Deep-Idle Controller

This block decides, clock by clock, whether a switching power stage may fire, based on a digitised feedback level. When the feedback code drops under a stop level, switching is withheld; it comes back only once the code climbs over a higher resume level. The gap between the two levels gives hysteresis. While switching is withheld the block measures how long the idle interval lasts. If the idle interval lasts a full entry window, the block enters a deep low-power state and raises a flag that other logic uses to cut its own supply current.

The block leaves the deep state through a short wake-up phase. During wake-up the internal state is cleared, then switching is enabled again. The wake-up phase lasts a fixed, parameter-set number of clocks, which keeps the exit latency bounded. A second output picks one of three minimum peak-current floors from the feedback level. That selection is re-evaluated only once per internal switching period, so it cannot glitch in between. The floor voltages themselves are produced by analog circuitry.

Top module: `burst_gate`

## Requirements
- R1: After reset, `swEn` is 1, `lowPower` is 0 and `floorSel` is 2'b00.
- R2: While switching is enabled, a feedback code strictly below `STOP_CODE` clears `swEn` at the next clock edge. A code equal to `STOP_CODE` keeps switching enabled.
- R3: In burst idle (not deep, not waking), a code strictly above `RESUME_CODE` sets `swEn` at the next clock edge. A code equal to `RESUME_CODE` does not.
- R4: A code from `STOP_CODE` to `RESUME_CODE` inclusive leaves `swEn` unchanged in both the running state and the idle state.
- R5: Once `swEn` has fallen, `lowPower` rises exactly `ENTRY_CLKS` clock edges later, provided the code never rose above `RESUME_CODE` in the meantime. `swEn` is 0 whenever `lowPower` is 1.
- R6: Any cycle in which the code is above `RESUME_CODE` restarts the idle-interval measurement from zero.
- R7: In the deep state, a code above `RESUME_CODE` clears `lowPower` at the next edge. `swEn` then rises exactly `WAKE_CLKS` edges later. The parameter rule is `WAKE_CLKS` <= the allowed exit latency. A code at or below `RESUME_CODE` leaves the deep state in place.
- R8: During the wake-up phase, `swEn` stays 0, the floor select is forced to 2'b00, and the floor-period timer restarts when the phase ends.
- R9: The floor code is 2'b00 (low) for a code <= `RESUME_CODE`, 2'b01 (mid) for `RESUME_CODE` < code <= `FOLD_CODE`, and 2'b10 (high) for a code > `FOLD_CODE`. The value 2'b11 never appears.
- R10: `floorSel` changes only at floor-period ticks. Ticks fall every `FLOOR_PERIOD` clock edges, counted from reset release, or from the end of wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fbCode | input | FB_W | Digitised feedback level |
| swEn | output | 1 | Switching permitted |
| lowPower | output | 1 | Deep low-power state active |
| floorSel | output | 2 | Minimum peak-current floor select |

## Verification
The hardest situation to reach is the one in the middle of R6 and R8. There, a short feedback excursion during idle must restart the entry window. Later, a wake-up must restart the floor-period phase. Both effects are invisible unless the bench measures timing against the exact edge counts. The stimulus first starts an idle interval. It then injects a one-cycle excursion above the resume level, and checks that `lowPower` is still low at the edge where the un-restarted window would have expired. It checks `lowPower` again at the edge where the restarted window ends. Finally it wakes the block with a high feedback code and checks that the floor stays low through the old tick phase. The floor must reach the high code only one full period after wake-up ends.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_DEEP = 2'd2,
    ST_WAKE = 2'd3
  } burstState_t;

  typedef enum logic [1:0] {
    FLOOR_LOW  = 2'b00,
    FLOOR_MID  = 2'b01,
    FLOOR_HIGH = 2'b10
  } floorSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic holdDwell;  // keep the dwell counter at zero
    logic wakeRst;    // internal reset during wake-up
  } ctrlStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic belowStop;
    logic aboveResume;
    logic entryDone;
    logic wakeDone;
  } dpFlags_t;

endpackage

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int FB_W         = 10,
  parameter int STOP_CODE    = 140,
  parameter int RESUME_CODE  = 150,
  parameter int FOLD_CODE    = 250,
  parameter int ENTRY_CLKS   = 128000,
  parameter int WAKE_CLKS    = 4000,
  parameter int FLOOR_PERIOD = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fbCode,
  input  ctrlStrobe_t     strb,
  output dpFlags_t        flags,
  output logic [1:0]      floorSel
);

  localparam int DWELL_MAX = (ENTRY_CLKS > WAKE_CLKS) ? ENTRY_CLKS : WAKE_CLKS;
  localparam int DW_W      = $clog2(DWELL_MAX + 1);
  localparam int PER_W     = $clog2(FLOOR_PERIOD + 1);

  localparam logic [FB_W-1:0]  STOP_V    = FB_W'(STOP_CODE);
  localparam logic [FB_W-1:0]  RESUME_V  = FB_W'(RESUME_CODE);
  localparam logic [FB_W-1:0]  FOLD_V    = FB_W'(FOLD_CODE);
  localparam logic [DW_W-1:0]  ENTRY_END = DW_W'(ENTRY_CLKS - 1);
  localparam logic [DW_W-1:0]  WAKE_END  = DW_W'(WAKE_CLKS - 1);
  localparam logic [DW_W-1:0]  DW_SAT    = DW_W'(DWELL_MAX);
  localparam logic [PER_W-1:0] PER_LAST  = PER_W'(FLOOR_PERIOD - 1);

  logic [DW_W-1:0]  dwellCnt;
  logic [PER_W-1:0] perCnt;
  floorSel_t        floorReg;
  floorSel_t        levelNow;

  // level comparisons
  always_comb begin
    flags.belowStop   = fbCode < STOP_V;
    flags.aboveResume = fbCode > RESUME_V;
    flags.entryDone   = dwellCnt == ENTRY_END;
    flags.wakeDone    = dwellCnt == WAKE_END;
  end

  // shared dwell counter: idle interval and wake-up length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwellCnt <= '0;
    end else if (strb.holdDwell) begin
      dwellCnt <= '0;
    end else if (dwellCnt != DW_SAT) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  // three-level floor classification
  always_comb begin
    if (fbCode > FOLD_V)        levelNow = FLOOR_HIGH;
    else if (fbCode > RESUME_V) levelNow = FLOOR_MID;
    else                        levelNow = FLOOR_LOW;
  end

  // floor select sampled once per period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perCnt   <= '0;
      floorReg <= FLOOR_LOW;
    end else if (strb.wakeRst) begin
      perCnt   <= '0;
      floorReg <= FLOOR_LOW;
    end else if (perCnt == PER_LAST) begin
      perCnt   <= '0;
      floorReg <= levelNow;
    end else begin
      perCnt   <= perCnt + 1'b1;
    end
  end

  assign floorSel = floorReg;

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strb,
  output logic        swEn,
  output logic        lowPower
);

  burstState_t state;
  burstState_t stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (flags.belowStop) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (flags.aboveResume)    stateNext = ST_RUN;
        else if (flags.entryDone) stateNext = ST_DEEP;
      end
      ST_DEEP: if (flags.aboveResume) stateNext = ST_WAKE;
      ST_WAKE: if (flags.wakeDone)    stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= stateNext;
  end

  always_comb begin
    strb.holdDwell = (state == ST_RUN) || (state == ST_DEEP);
    strb.wakeRst   = (state == ST_WAKE);
    swEn           = (state == ST_RUN);
    lowPower       = (state == ST_DEEP);
  end

endmodule

// File: rtl/burst_gate.sv
module burst_gate
  import burst_pkg::*;
#(
  parameter int FB_W         = 10,
  parameter int STOP_CODE    = 140,
  parameter int RESUME_CODE  = 150,
  parameter int FOLD_CODE    = 250,
  parameter int ENTRY_CLKS   = 128000,
  parameter int WAKE_CLKS    = 4000,
  parameter int FLOOR_PERIOD = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fbCode,
  output logic            swEn,
  output logic            lowPower,
  output logic [1:0]      floorSel
);

  ctrlStrobe_t strb;
  dpFlags_t    flags;

  burst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .strb     (strb),
    .swEn     (swEn),
    .lowPower (lowPower)
  );

  burst_dp #(
    .FB_W         (FB_W),
    .STOP_CODE    (STOP_CODE),
    .RESUME_CODE  (RESUME_CODE),
    .FOLD_CODE    (FOLD_CODE),
    .ENTRY_CLKS   (ENTRY_CLKS),
    .WAKE_CLKS    (WAKE_CLKS),
    .FLOOR_PERIOD (FLOOR_PERIOD)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fbCode   (fbCode),
    .strb     (strb),
    .flags    (flags),
    .floorSel (floorSel)
  );

endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk #(
  parameter int FB_W         = 10,
  parameter int STOP_CODE    = 140,
  parameter int RESUME_CODE  = 150,
  parameter int ENTRY_CLKS   = 128000,
  parameter int WAKE_CLKS    = 4000,
  parameter int FLOOR_PERIOD = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FB_W-1:0] fbCode,
  input logic            swEn,
  input logic            lowPower,
  input logic [1:0]      floorSel,
  input logic            inWake
);

  localparam logic [FB_W-1:0] STOP_V   = FB_W'(STOP_CODE);
  localparam logic [FB_W-1:0] RESUME_V = FB_W'(RESUME_CODE);

  int         idleRun;
  int         wakeRun;
  int         floorGap;
  logic [1:0] floorQ;
  logic       wakeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleRun  <= 0;
      wakeRun  <= 0;
      floorGap <= 0;
      floorQ   <= 2'b00;
      wakeQ    <= 1'b0;
    end else begin
      idleRun <= (!swEn && !lowPower && !inWake) ? idleRun + 1 : 0;
      wakeRun <= inWake ? wakeRun + 1 : 0;
      floorQ  <= floorSel;
      wakeQ   <= inWake;
      if (inWake)                 floorGap <= 0;
      else if (floorSel != floorQ) floorGap <= 1;
      else if (floorGap < FLOOR_PERIOD) floorGap <= floorGap + 1;
    end
  end

  a_r2_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (swEn && fbCode < STOP_V) |=> !swEn);

  a_r4_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (swEn && fbCode >= STOP_V) |=> swEn);

  a_r3_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (!swEn && !lowPower && !inWake && fbCode > RESUME_V) |=> swEn);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!swEn && !lowPower && !inWake && fbCode <= RESUME_V) |=> !swEn);

  a_r5_entry_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowPower) |-> (idleRun == ENTRY_CLKS));

  a_r5_quiet_in_deep: assert property (@(posedge clk) disable iff (!rst_n)
    lowPower |-> !swEn);

  a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (lowPower && fbCode > RESUME_V) |=> (!lowPower && inWake));

  a_r7_wake_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inWake) |-> (wakeRun == WAKE_CLKS && swEn));

  a_r8_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inWake |-> (!swEn && wakeRun < WAKE_CLKS));

  a_r8_wake_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (inWake && wakeQ) |-> (floorSel == 2'b00));

  a_r9_code: assert property (@(posedge clk) disable iff (!rst_n)
    floorSel != 2'b11);

  a_r10_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!inWake && !wakeQ && floorSel != floorQ) |-> (floorGap >= FLOOR_PERIOD));

endmodule

bind burst_gate burst_gate_chk #(
  .FB_W         (FB_W),
  .STOP_CODE    (STOP_CODE),
  .RESUME_CODE  (RESUME_CODE),
  .ENTRY_CLKS   (ENTRY_CLKS),
  .WAKE_CLKS    (WAKE_CLKS),
  .FLOOR_PERIOD (FLOOR_PERIOD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fbCode   (fbCode),
  .swEn     (swEn),
  .lowPower (lowPower),
  .floorSel (floorSel),
  .inWake   (strb.wakeRst)
);

// File: tb/burst_gate_tb.sv
`timescale 1ns/1ps
module burst_gate_tb;

  localparam int FB_W = 10;
  localparam int ENTRY = 40;
  localparam int WAKE  = 6;
  localparam int PER   = 8;

  typedef struct {
    int         at;
    logic [2:0] mask;   // [2]=swEn [1]=lowPower [0]=floorSel
    logic       sw;
    logic       lp;
    logic [1:0] fl;
    string      tag;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [FB_W-1:0] fbCode = 10'd300;
  logic            swEn, lowPower;
  logic [1:0]      floorSel;

  int       cyc = 0;
  int       nChecks = 0;
  int       nFail = 0;
  int       tickBase = 0;
  bit       done = 1'b0;
  expItem_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_gate #(
    .FB_W(FB_W), .STOP_CODE(140), .RESUME_CODE(150), .FOLD_CODE(250),
    .ENTRY_CLKS(ENTRY), .WAKE_CLKS(WAKE), .FLOOR_PERIOD(PER)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fbCode(fbCode),
    .swEn(swEn), .lowPower(lowPower), .floorSel(floorSel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: expected outputs at a later negedge
  task automatic pushExp(input int delta, input logic [2:0] mask, input logic sw,
                         input logic lp, input logic [1:0] fl, input string tag);
    expItem_t it;
    it.at = cyc + delta; it.mask = mask; it.sw = sw; it.lp = lp; it.fl = fl; it.tag = tag;
    sb.push_back(it);
  endtask

  // edges until the next floor-period tick
  function automatic int nextTick();
    int d;
    d = ((tickBase - cyc) % PER + PER) % PER;
    if (d == 0) d = PER;
    return d;
  endfunction

  // monitor side
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        nChecks++;
        if ((sb[i].mask[2] && swEn !== sb[i].sw) ||
            (sb[i].mask[1] && lowPower !== sb[i].lp) ||
            (sb[i].mask[0] && floorSel !== sb[i].fl)) begin
          nFail++;
          $display("FAIL %s at cycle %0d: swEn=%0b lowPower=%0b floorSel=%02b, expected swEn=%0b lowPower=%0b floorSel=%02b (mask %03b)",
                   sb[i].tag, cyc, swEn, lowPower, floorSel, sb[i].sw, sb[i].lp, sb[i].fl, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int d;
    step(3);
    rst_n = 1'b1;                     // released at negedge; ticks every PER edges from here
    tickBase = cyc;
    pushExp(1, 3'b111, 1'b1, 1'b0, 2'b00, "R1 reset state");
    pushExp(7, 3'b001, 1'b0, 1'b0, 2'b00, "R10 floor held before first tick");
    pushExp(8, 3'b001, 1'b0, 1'b0, 2'b10, "R9 high floor above fold");
    step(9);

    fbCode = 10'd200;                 // mid band
    d = nextTick();
    pushExp(1, 3'b100, 1'b1, 1'b0, 2'b00, "R4 running above resume");
    pushExp(d - 1, 3'b001, 1'b0, 1'b0, 2'b10, "R10 floor unchanged between ticks");
    pushExp(d, 3'b001, 1'b0, 1'b0, 2'b01, "R9 mid floor");
    step(d + 1);

    fbCode = 10'd145;                 // hysteresis band
    d = nextTick();
    pushExp(1, 3'b100, 1'b1, 1'b0, 2'b00, "R4 band keeps switching");
    pushExp(d, 3'b001, 1'b0, 1'b0, 2'b00, "R9 low floor at or below resume");
    step(d + 1);

    fbCode = 10'd100;                 // below stop
    pushExp(1, 3'b110, 1'b0, 1'b0, 2'b00, "R2 stop");
    step(1);
    fbCode = 10'd145;
    pushExp(2, 3'b110, 1'b0, 1'b0, 2'b00, "R4 band keeps idle");
    step(3);

    fbCode = 10'd160;                 // one-cycle excursion
    pushExp(1, 3'b110, 1'b1, 1'b0, 2'b00, "R3 resume");
    step(1);
    fbCode = 10'd100;
    pushExp(1, 3'b110, 1'b0, 1'b0, 2'b00, "R2 stop again");
    step(1);                          // idle state begins at this edge
    pushExp(ENTRY - 5, 3'b010, 1'b0, 1'b0, 2'b00, "R6 window restarted by excursion");
    pushExp(ENTRY - 1, 3'b110, 1'b0, 1'b0, 2'b00, "R5 not deep one edge early");
    pushExp(ENTRY, 3'b110, 1'b0, 1'b1, 2'b00, "R5 deep entry");
    step(ENTRY + 2);

    fbCode = 10'd150;                 // equal to resume: no wake
    pushExp(3, 3'b110, 1'b0, 1'b1, 2'b00, "R7 resume level does not wake");
    step(4);

    fbCode = 10'd300;                 // wake
    pushExp(1, 3'b110, 1'b0, 1'b0, 2'b00, "R7 lowPower clears");
    pushExp(3, 3'b101, 1'b0, 1'b0, 2'b00, "R8 floor forced low in wake");
    pushExp(WAKE, 3'b100, 1'b0, 1'b0, 2'b00, "R8 no switching during wake");
    pushExp(WAKE + 1, 3'b110, 1'b1, 1'b0, 2'b00, "R7 switching after wake");
    pushExp(WAKE + 1 + PER - 1, 3'b001, 1'b0, 1'b0, 2'b00, "R8 floor timer restarted");
    pushExp(WAKE + 1 + PER, 3'b001, 1'b0, 1'b0, 2'b10, "R9 high floor after wake");
    tickBase = cyc + WAKE + 1;
    step(WAKE + 1 + PER + 1);

    fbCode = 10'd140;                 // equal to stop
    pushExp(1, 3'b100, 1'b1, 1'b0, 2'b00, "R2 stop level keeps switching");
    step(2);
    fbCode = 10'd139;
    pushExp(1, 3'b100, 1'b0, 1'b0, 2'b00, "R2 one below stop");
    step(2);
    fbCode = 10'd150;
    pushExp(2, 3'b100, 1'b0, 1'b0, 2'b00, "R3 resume level keeps idle");
    step(3);
    fbCode = 10'd151;
    pushExp(1, 3'b100, 1'b1, 1'b0, 2'b00, "R3 one above resume");
    step(1);

    fbCode = 10'd250;                 // fold boundary
    d = nextTick();
    pushExp(d, 3'b001, 1'b0, 1'b0, 2'b01, "R9 fold code maps to mid");
    step(d + 1);
    fbCode = 10'd251;
    d = nextTick();
    pushExp(d, 3'b001, 1'b0, 1'b0, 2'b10, "R9 above fold maps to high");
    step(d + 2);

    if (sb.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: %0d expected items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule